// File: doc/BRIEF.md
# Bit-Serial Memory Request Target

This block is the responding end of a one-bit serial request link. A requester sends 64-bit segments one bit per cycle, least significant bit first. A one-cycle strobe on the request valid line marks bit 0 of each segment. The target collects a header segment and decodes its opcode byte. For a write it also collects a 64-bit data segment. It then performs the access on a small internal memory of 64-bit words.

A read is answered on a separate return channel. The channel carries a one-cycle valid pulse, then the 64-bit word, least significant bit first. A write is answered with a lone valid pulse after the word has been stored. Headers that fail the opcode or reserved-field checks get no reply. Each one bumps a saturating error counter that is visible at a port. The reply delay, counted from the last request bit, is a fixed parameter of at least 3 cycles.

Top module: `serMemTarget`

## Requirements
- R1: After reset `rspValid` and `rspData` are 0 and `errCount` is 0. Every memory word reads back as zero until it is written.
- R2: A segment starts in the cycle where `reqValid` is 1, and that cycle carries bit 0. The next 63 cycles carry bits 1 to 63.
- R3: A header whose bits [63:56] equal 0x81 and whose bits [55:40] are zero is a read. `rspValid` is 1 for exactly one cycle, LATENCY cycles after the last header bit (default 3). In the following 64 cycles `rspData` carries the addressed word, bit 0 first.
- R4: A header with opcode 0x82 is a write. The data segment carries its own `reqValid` strobe. It may start in the cycle right after the last header bit or any later cycle. The word is stored, and a one-cycle `rspValid` pulse with no payload follows, LATENCY cycles after the last data bit.
- R5: `rspData` is 0 in every cycle that is not one of the 64 payload cycles of a read reply, including the cycle of the `rspValid` pulse.
- R6: A header with any other opcode, or with non-zero bits [55:40], produces no reply. It increments `errCount` by one, and the count saturates at its maximum.
- R7: The word index is taken from address bits [log2(WORDS)+2:3], the address being header bits [39:0]. Address bits [2:0] and the bits above the index are ignored, so aliased addresses reach the same word.
- R8: A `reqValid` strobe that arrives while a request is being decoded, delayed or answered is ignored. No reply and no error count result from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | One-cycle strobe marking bit 0 of a request segment |
| reqData | input | 1 | Serial request bit, LSB first |
| rspValid | output | 1 | One-cycle reply strobe |
| rspData | output | 1 | Serial read payload, LSB first, 0 when idle |
| errCount | output | ERR_W | Saturating count of dropped headers |

## Verification
Two things can happen in the same cycle: the decode of a write header and the capture of bit 0 of its data segment. This happens when the data strobe follows the last header bit with no gap. The bench sends writes both back-to-back and with an idle gap before the data segment. The scoreboard then judges each case by its acknowledge cycle and by reading the stored word back. A second overlap is a new request strobe arriving while a read reply is still streaming out. The bench provokes it and then confirms that no extra reply appears and that the error count does not move.

// File: rtl/serTgtPkg.sv
package serTgtPkg;
  localparam logic [7:0] OP_READ  = 8'h81;
  localparam logic [7:0] OP_WRITE = 8'h82;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic latchAddr;
    logic memWrite;
    logic loadRsp;
    logic sendData;
    logic bumpErr;
  } tgtStrobe_t;
endpackage

// File: rtl/serTgtPath.sv
module serTgtPath
  import serTgtPkg::*;
#(
  parameter int WORDS = 16,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqData,
  input  tgtStrobe_t       strobe,
  output logic             hdrOk,
  output logic             hdrWrite,
  output logic             rspData,
  output logic [ERR_W-1:0] errCount
);
  localparam int IDXW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [63:0]     inShift;
  logic [63:0]     rspShift;
  logic [IDXW-1:0] addrIdx;
  logic [IDXW-1:0] hdrIdx;
  logic [63:0]     memWord [WORDS];
  logic [7:0]      opByte;

  assign opByte   = inShift[63:56];
  assign hdrIdx   = inShift[IDXW+2:3];
  assign hdrWrite = (opByte == OP_WRITE);
  assign hdrOk    = (inShift[55:40] == 16'h0) && (opByte == OP_READ || opByte == OP_WRITE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inShift <= '0;
    else if (strobe.shiftIn) inShift <= {reqData, inShift[63:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrIdx <= '0;
    else if (strobe.latchAddr) addrIdx <= hdrIdx;
  end

  // one register row per word
  for (genvar w = 0; w < WORDS; w++) begin : gWord
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) memWord[w] <= '0;
      else if (strobe.memWrite && addrIdx == IDXW'(w)) memWord[w] <= inShift;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspShift <= '0;
    else if (strobe.loadRsp) rspShift <= memWord[hdrIdx];
    else if (strobe.sendData) rspShift <= {1'b0, rspShift[63:1]};
  end

  assign rspData = strobe.sendData & rspShift[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errCount <= '0;
    else if (strobe.bumpErr && errCount != {ERR_W{1'b1}}) errCount <= errCount + 1'b1;
  end

  assert_err_monotonic_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> errCount >= $past(errCount));
endmodule

// File: rtl/serTgtCtl.sv
module serTgtCtl
  import serTgtPkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       hdrOk,
  input  logic       hdrWrite,
  output tgtStrobe_t strobe,
  output logic       rspValid
);
  localparam int DLYW = (LATENCY > 3) ? $clog2(LATENCY - 2) : 1;
  localparam logic [DLYW-1:0] DLY_INIT = DLYW'(LATENCY - 3);

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_DEC, S_WGAP, S_DAT, S_COMMIT, S_WAIT, S_ACK, S_RDAT
  } tgtState_e;

  tgtState_e       state, stateNxt;
  logic [5:0]      bitCnt, bitNxt;
  logic [DLYW-1:0] dly, dlyNxt;
  logic            opWr, opWrNxt;

  always_comb begin
    strobe   = '0;
    rspValid = 1'b0;
    stateNxt = state;
    bitNxt   = bitCnt;
    dlyNxt   = dly;
    opWrNxt  = opWr;
    case (state)
      S_IDLE: if (reqValid) begin
        strobe.shiftIn = 1'b1; bitNxt = 6'd1; stateNxt = S_HDR;
      end
      S_HDR: begin
        strobe.shiftIn = 1'b1; bitNxt = bitCnt + 6'd1;
        if (bitCnt == 6'd63) stateNxt = S_DEC;
      end
      S_DEC: begin
        if (!hdrOk) begin
          strobe.bumpErr = 1'b1; stateNxt = S_IDLE;
        end else if (hdrWrite) begin
          strobe.latchAddr = 1'b1; opWrNxt = 1'b1;
          if (reqValid) begin
            strobe.shiftIn = 1'b1; bitNxt = 6'd1; stateNxt = S_DAT;
          end else stateNxt = S_WGAP;
        end else begin
          strobe.loadRsp = 1'b1; opWrNxt = 1'b0; dlyNxt = DLY_INIT; stateNxt = S_WAIT;
        end
      end
      S_WGAP: if (reqValid) begin
        strobe.shiftIn = 1'b1; bitNxt = 6'd1; stateNxt = S_DAT;
      end
      S_DAT: begin
        strobe.shiftIn = 1'b1; bitNxt = bitCnt + 6'd1;
        if (bitCnt == 6'd63) stateNxt = S_COMMIT;
      end
      S_COMMIT: begin
        strobe.memWrite = 1'b1; dlyNxt = DLY_INIT; stateNxt = S_WAIT;
      end
      S_WAIT: begin
        if (dly == '0) stateNxt = S_ACK;
        else dlyNxt = dly - 1'b1;
      end
      S_ACK: begin
        rspValid = 1'b1; bitNxt = 6'd0;
        stateNxt = opWr ? S_IDLE : S_RDAT;
      end
      S_RDAT: begin
        strobe.sendData = 1'b1; bitNxt = bitCnt + 6'd1;
        if (bitCnt == 6'd63) stateNxt = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; bitCnt <= '0; dly <= '0; opWr <= 1'b0;
    end else begin
      state <= stateNxt; bitCnt <= bitNxt; dly <= dlyNxt; opWr <= opWrNxt;
    end
  end

  // cycles elapsed since the last request bit, for the latency check
  logic [31:0] sinceLast;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceLast <= '0;
    else if (state == S_DEC || state == S_COMMIT) sinceLast <= 32'd2;
    else if (sinceLast != 32'hFFFF_FFFF) sinceLast <= sinceLast + 32'd1;
  end

  assert_reply_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> sinceLast == 32'(LATENCY));
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT || state == S_ACK || state == S_RDAT || state == S_COMMIT)
      |=> state != S_HDR && state != S_DAT);
endmodule

// File: rtl/serMemTarget.sv
module serMemTarget #(
  parameter int WORDS   = 16,
  parameter int LATENCY = 3,
  parameter int ERR_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqData,
  output logic             rspValid,
  output logic             rspData,
  output logic [ERR_W-1:0] errCount
);
  serTgtPkg::tgtStrobe_t strobe;
  logic hdrOk, hdrWrite;

  serTgtCtl #(.LATENCY(LATENCY)) uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .hdrOk(hdrOk), .hdrWrite(hdrWrite), .strobe(strobe), .rspValid(rspValid)
  );

  serTgtPath #(.WORDS(WORDS), .ERR_W(ERR_W)) uPath (
    .clk(clk), .rstN(rstN), .reqData(reqData), .strobe(strobe),
    .hdrOk(hdrOk), .hdrWrite(hdrWrite), .rspData(rspData), .errCount(errCount)
  );

  assert_quiet_on_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !rspData);
endmodule

// File: tb/sim_serMemTarget.sv
`timescale 1ns/1ps
module sim_serMemTarget;
  localparam int LAT   = 3;
  localparam int NW    = 16;
  localparam int ERR_W = 8;

  typedef struct {
    bit          isRead;
    logic [63:0] data;
    int          due;
    string       tag;
  } expItem_t;

  logic clk = 1'b0, rstN = 1'b0, reqValid = 1'b0, reqData = 1'b0;
  logic rspValid, rspData;
  logic [ERR_W-1:0] errCount;

  int total = 0, bad = 0, cyc = 0, lastCyc = 0;
  int unexpected = 0, strayHigh = 0;
  bit collecting = 1'b0;
  expItem_t sb[$];
  logic [63:0] model [NW];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serMemTarget #(.WORDS(NW), .LATENCY(LAT), .ERR_W(ERR_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqData(reqData),
    .rspValid(rspValid), .rspData(rspData), .errCount(errCount)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations as replies appear
  initial begin
    expItem_t it;
    int idx;
    logic [63:0] got;
    idx = 0; got = '0;
    forever begin
      @(negedge clk);
      if (!rstN) continue;
      if (collecting) begin
        got[idx] = rspData;
        idx++;
        if (idx == 64) begin
          collecting = 1'b0;
          check(got == it.data, {it.tag, " read payload"}, got, it.data);
        end
      end else begin
        if (rspData) strayHigh++;
        if (rspValid) begin
          if (sb.size() == 0) begin
            unexpected++;
            check(1'b0, "R8/R6 unexpected reply", 64'd1, 64'd0);
          end else begin
            it = sb.pop_front();
            check(cyc == it.due, {it.tag, " reply cycle"}, 64'(cyc), 64'(it.due));
            if (it.isRead) begin collecting = 1'b1; idx = 0; got = '0; end
          end
        end
      end
    end
  end

  function automatic logic [63:0] mkHdr(input logic [7:0] op, input logic [15:0] rsv, input logic [39:0] a);
    return {op, rsv, a};
  endfunction

  task automatic sendSeg(input logic [63:0] w);
    for (int i = 0; i < 64; i++) begin
      @(posedge clk); #1;
      reqValid = (i == 0);
      reqData  = w[i];
    end
    lastCyc = cyc;
  endtask

  task automatic quiet();
    @(posedge clk); #1;
    reqValid = 1'b0; reqData = 1'b0;
  endtask

  task automatic drain();
    wait (sb.size() == 0 && !collecting);
    repeat (4) @(posedge clk);
  endtask

  task automatic doRead(input logic [39:0] a, input string tag);
    expItem_t it;
    sendSeg(mkHdr(8'h81, 16'h0, a));
    it.isRead = 1'b1; it.data = model[a[6:3]]; it.due = lastCyc + LAT; it.tag = tag;
    sb.push_back(it);
    quiet();
    drain();
  endtask

  task automatic doWrite(input logic [39:0] a, input logic [63:0] d, input int gap, input string tag);
    expItem_t it;
    sendSeg(mkHdr(8'h82, 16'h0, a));
    if (gap > 0) begin
      quiet();
      repeat (gap - 1) @(posedge clk);
    end
    sendSeg(d);
    model[a[6:3]] = d;
    it.isRead = 1'b0; it.data = '0; it.due = lastCyc + LAT; it.tag = tag;
    sb.push_back(it);
    quiet();
    drain();
  endtask

  task automatic doBad(input logic [63:0] h);
    sendSeg(h);
    quiet();
    repeat (LAT + 80) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    expItem_t it;
    for (int i = 0; i < NW; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(rspValid == 1'b0, "R1 rspValid after reset", 64'(rspValid), 64'd0);
    check(rspData == 1'b0, "R1 rspData after reset", 64'(rspData), 64'd0);
    check(errCount == '0, "R1 errCount after reset", 64'(errCount), 64'd0);
    doRead(40'h40, "R1 R3 unwritten word");

    // R2 R4: back-to-back data segment (decode and capture overlap)
    doWrite(40'h08, 64'hDEAD_BEEF_0123_4567, 0, "R4 write no gap");
    doRead(40'h08, "R2 R3 readback no-gap write");
    // R4: data segment after idle gap
    doWrite(40'h10, 64'h8000_0000_0000_0001, 5, "R4 write gap");
    doRead(40'h10, "R3 readback gapped write");
    doWrite(40'h78, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R4 write ones");
    doRead(40'h78, "R2 readback ones");

    // R7: low bits and upper bits ignored
    doWrite(40'h1D, 64'hA5A5_5A5A_C3C3_3C3C, 0, "R7 write unaligned");
    doRead(40'h18, "R7 aligned read");
    doRead(40'h98, "R7 alias above index");
    doRead(40'h80_0000_001F, "R7 high and low bits");

    // R6: bad opcode and reserved bits
    doBad(mkHdr(8'h83, 16'h0, 40'h08));
    check(errCount == 8'd1, "R6 bad opcode count", 64'(errCount), 64'd1);
    doBad(mkHdr(8'h81, 16'h0100, 40'h08));
    check(errCount == 8'd2, "R6 reserved bits count", 64'(errCount), 64'd2);
    check(unexpected == 0, "R6 no reply to bad header", 64'(unexpected), 64'd0);
    doRead(40'h08, "R6 memory intact after bad header");

    // R8: request strobe while a read reply is streaming
    sendSeg(mkHdr(8'h81, 16'h0, 40'h10));
    it.isRead = 1'b1; it.data = model[2]; it.due = lastCyc + LAT; it.tag = "R8 reply under traffic";
    sb.push_back(it);
    quiet();
    repeat (4) @(posedge clk);
    sendSeg(mkHdr(8'h81, 16'h0, 40'h08));
    quiet();
    drain();
    repeat (LAT + 80) @(posedge clk);
    check(unexpected == 0, "R8 busy strobe ignored", 64'(unexpected), 64'd0);
    check(errCount == 8'd2, "R8 errCount unchanged", 64'(errCount), 64'd2);

    // R5: no stray data outside payload
    check(strayHigh == 0, "R5 rspData idle low", 64'(strayHigh), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule